// File: doc/BRIEF.md
# Message-Object Window Transfer Engine

This block sits between a 16-bit host register bus and a small RAM of 32 message objects for a CAN controller. The host never touches the RAM directly. It fills one of two identical register windows instead. Each window holds a request register, a command mask, two mask words, two arbitration words, a control word and four data words. The host then writes an object number into the window's request register. A fixed-length sequencer copies the sections that the command mask selects, in the direction the mask names. The busy bit in the request register reads 1 for as long as the copy runs.

The two windows are independent. One can run a transfer while the host sets up the other, so a receive path and a transmit path never share a staging area. Two things can happen as part of a single transfer. A store can set the object's transmit request, and a load can clear the object's new-data flag. The transmit-request, new-data and message-valid flag of every object are also brought out as flat vectors, for the bus-side logic next to this block.

Top module: `msgobj_xfer`

## Requirements
- R1: After reset, every window register reads 0, both busy bits read 0, and the three flag vectors are 0.
- R2: Address bit 4 selects the window: 0 selects window 1 and 1 selects window 2. Address bits 3:0 give the register offset. A host write to offset 0 (the request register) of an idle window starts a transfer to object number wdata[5:0]. Bit 15 of offset 0 (busy) reads 1 for exactly 4 clock cycles after the write edge. Offset 0 bits 5:0 read back the number that was written. The results are visible once busy reads 0.
- R3: Offset 1 is the command mask, 8 bits wide. Each bit selects one section: bit 0 selects control (offset 6), bit 1 arbitration (offsets 4 and 5), bit 2 mask (offsets 2 and 3), bit 3 data A (offsets 7 and 8, bytes 0 to 3), and bit 4 data B (offsets 9 and 10, bytes 4 to 7). Bit 6 gives the direction: 1 stores window to object, 0 loads object to window. Sections that are not selected keep their old value on both sides.
- R4: A store with mask bit 5 set leaves control bit 8 (transmit request) of the object at 1. This holds whether or not the control section is selected. On a load, bit 5 has no effect.
- R5: A load with mask bits 0 and 7 both set gives the window the object's control word unchanged. It then clears control bit 15 (new data) in the object. On a store, bit 7 has no effect.
- R6: Each word of an object is stored verbatim. Output bit i of txreq_vec is control bit 8 of object i+1. Bit i of newdat_vec is control bit 15 of object i+1. Bit i of msgval_vec is arbitration-word-2 bit 15 of object i+1. The vectors change only in the cycle in which a transfer completes.
- R7: While a window is busy, host writes to any of its registers are ignored, including a new request. Writes to the other window still take effect.
- R8: An object number of 0 or of 33 to 63 makes busy read 1 for exactly one cycle and changes no object.
- R9: Offsets 11 to 15 read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr | input | 1 | Host write strobe |
| addr | input | 5 | Bit 4 selects the window; bits 3:0 give the register offset |
| wdata | input | 16 | Host write data |
| rdata | output | 16 | Read data of the addressed register (combinational) |
| txreq_vec | output | 32 | Transmit-request flag of each object |
| newdat_vec | output | 32 | New-data flag of each object |
| msgval_vec | output | 32 | Message-valid flag of each object |

## Verification
The assertions check four things on every cycle:
- A request to an idle window raises busy on the next cycle.
- A busy period lasts either the full transfer length or a single cycle, so a request made mid-transfer cannot stretch it.
- A bad object number gives the one-cycle pulse.
- The flag vectors move only when a busy bit falls.

Three behaviours need the bench's scenarios, checked against a reference model of the object RAM:
- which sections a given mask copies, and in which direction;
- the transmit-request and new-data side effects;
- the data a busy window keeps after a write to it was ignored.

// File: rtl/msgobj_xfer.sv
module msgobj_xfer #(
  parameter int NOBJ     = 32,
  parameter int XFER_CYC = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr,
  input  logic [4:0]      addr,
  input  logic [15:0]     wdata,
  output logic [15:0]     rdata,
  output logic [NOBJ-1:0] txreq_vec,
  output logic [NOBJ-1:0] newdat_vec,
  output logic [NOBJ-1:0] msgval_vec
);
  localparam int OW = $clog2(NOBJ + 1);
  localparam int IW = $clog2(NOBJ);
  localparam int CW = $clog2(XFER_CYC + 1);
  localparam int NSEC = 9;

  logic [15:0]   wreg [2][NSEC];
  logic [7:0]    wcm  [2];
  logic [OW-1:0] wobj [2];
  logic [CW-1:0] cnt  [2];
  logic [15:0]   ram  [NOBJ][NSEC];
  logic [1:0]    busy;
  logic [1:0]    done;
  logic [1:0]    obj_ok;
  logic [IW-1:0] obj_ix [2];
  logic          ws;
  logic [3:0]    off;
  logic          new_ok;

  assign ws  = addr[4];
  assign off = addr[3:0];
  assign new_ok = (wdata[OW-1:0] != '0) && (wdata[OW-1:0] <= OW'(NOBJ));

  for (genvar w = 0; w < 2; w++) begin : g_win
    assign busy[w]   = cnt[w] != '0;
    assign done[w]   = cnt[w] == CW'(1);
    assign obj_ok[w] = (wobj[w] != '0) && (wobj[w] <= OW'(NOBJ));
    assign obj_ix[w] = IW'(wobj[w] - OW'(1));
  end

  for (genvar i = 0; i < NOBJ; i++) begin : g_flag
    assign txreq_vec[i]  = ram[i][4][8];
    assign newdat_vec[i] = ram[i][4][15];
    assign msgval_vec[i] = ram[i][3][15];
  end

  function automatic logic sec_on(input int k, input logic [7:0] cm);
    case (k)
      0, 1:    sec_on = cm[2];
      2, 3:    sec_on = cm[1];
      4:       sec_on = cm[0];
      5, 6:    sec_on = cm[3];
      default: sec_on = cm[4];
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int w = 0; w < 2; w++) begin
        wcm[w]  <= '0;
        wobj[w] <= '0;
        cnt[w]  <= '0;
        for (int k = 0; k < NSEC; k++) wreg[w][k] <= '0;
      end
      for (int o = 0; o < NOBJ; o++)
        for (int k = 0; k < NSEC; k++) ram[o][k] <= '0;
    end else begin
      for (int w = 1; w >= 0; w--) begin
        if (wr && (ws == w[0]) && !busy[w]) begin
          if (off == 4'd0) begin
            wobj[w] <= wdata[OW-1:0];
            cnt[w]  <= new_ok ? CW'(XFER_CYC) : CW'(1);
          end else if (off == 4'd1) begin
            wcm[w] <= wdata[7:0];
          end else if (off <= 4'd10) begin
            wreg[w][off - 4'd2] <= wdata;
          end
        end else if (busy[w]) begin
          cnt[w] <= cnt[w] - CW'(1);
        end

        if (done[w] && obj_ok[w]) begin
          if (wcm[w][6]) begin
            for (int k = 0; k < NSEC; k++)
              if (sec_on(k, wcm[w])) ram[obj_ix[w]][k] <= wreg[w][k];
            if (wcm[w][5])
              ram[obj_ix[w]][4] <= (wcm[w][0] ? wreg[w][4] : ram[obj_ix[w]][4]) | 16'h0100;
          end else begin
            for (int k = 0; k < NSEC; k++)
              if (sec_on(k, wcm[w])) wreg[w][k] <= ram[obj_ix[w]][k];
            if (wcm[w][7] && wcm[w][0]) ram[obj_ix[w]][4][15] <= 1'b0;
          end
        end
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (off == 4'd0)       rdata = {busy[ws], {(15 - OW){1'b0}}, wobj[ws]};
    else if (off == 4'd1)  rdata = {8'h00, wcm[ws]};
    else if (off <= 4'd10) rdata = wreg[ws][off - 4'd2];
  end
endmodule

module msgobj_xfer_chk #(
  parameter int NOBJ     = 32,
  parameter int XFER_CYC = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wr,
  input logic [4:0]      addr,
  input logic [15:0]     wdata,
  input logic [1:0]      busy,
  input logic [NOBJ-1:0] txreq_vec,
  input logic [NOBJ-1:0] newdat_vec,
  input logic [NOBJ-1:0] msgval_vec
);
  logic [7:0] len0, len1;
  logic       bad_num;
  logic       req0, req1;

  assign bad_num = (wdata[5:0] == 6'd0) || (wdata[5:0] > 6'(NOBJ));
  assign req0 = wr && (addr == 5'h00) && !busy[0];
  assign req1 = wr && (addr == 5'h10) && !busy[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      len0 <= '0;
      len1 <= '0;
    end else begin
      len0 <= busy[0] ? len0 + 8'd1 : 8'd0;
      len1 <= busy[1] ? len1 + 8'd1 : 8'd0;
    end
  end

  p_start_busy_w0_r2: assert property (@(posedge clk) disable iff (!rst_n) req0 |=> busy[0]);
  p_start_busy_w1_r2: assert property (@(posedge clk) disable iff (!rst_n) req1 |=> busy[1]);

  p_busy_len_w0_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy[0]) |-> (len0 == 8'(XFER_CYC) || len0 == 8'd1));
  p_busy_len_w1_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy[1]) |-> (len1 == 8'(XFER_CYC) || len1 == 8'd1));

  p_bad_obj_short_w0_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req0 && bad_num) |=> busy[0] ##1 !busy[0]);
  p_bad_obj_short_w1_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req1 && bad_num) |=> busy[1] ##1 !busy[1]);

  p_vec_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!$fell(busy[0]) && !$fell(busy[1])) |->
      ($stable(txreq_vec) && $stable(newdat_vec) && $stable(msgval_vec)));
endmodule

bind msgobj_xfer msgobj_xfer_chk #(.NOBJ(NOBJ), .XFER_CYC(XFER_CYC)) u_chk (.*);

// File: tb/sim_msgobj_xfer.sv
`timescale 1ns/100ps
module sim_msgobj_xfer;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        wr = 0;
  logic [4:0]  addr = 0;
  logic [15:0] wdata = 0;
  logic [15:0] rdata;
  logic [31:0] txreq_vec, newdat_vec, msgval_vec;

  msgobj_xfer u0 (.*);

  always #2.5 clk = ~clk;

  int errors = 0, checks = 0;
  bit finished = 0;

  logic [15:0] mram [32][9];
  logic [15:0] mwin [2][9];
  logic [7:0]  mcm  [2];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input int w, input int off, input logic [15:0] d);
    @(negedge clk);
    wr = 1; addr = {w[0], off[3:0]}; wdata = d;
    @(negedge clk);
    wr = 0;
  endtask

  task automatic rd_reg(input int w, input int off, output logic [15:0] d);
    addr = {w[0], off[3:0]};
    #1 d = rdata;
  endtask

  function automatic bit sel(input int k, input logic [7:0] cm);
    if (k < 2) return cm[2];
    if (k < 4) return cm[1];
    if (k == 4) return cm[0];
    if (k < 7) return cm[3];
    return cm[4];
  endfunction

  task automatic model_xfer(input int w, input int obj);
    if (obj < 1 || obj > 32) return;
    if (mcm[w][6]) begin
      for (int k = 0; k < 9; k++) if (sel(k, mcm[w])) mram[obj-1][k] = mwin[w][k];
      if (mcm[w][5]) mram[obj-1][4] = mram[obj-1][4] | 16'h0100;
    end else begin
      for (int k = 0; k < 9; k++) if (sel(k, mcm[w])) mwin[w][k] = mram[obj-1][k];
      if (mcm[w][7] && mcm[w][0]) mram[obj-1][4][15] = 1'b0;
    end
  endtask

  function automatic logic [31:0] vec(input int kind);
    logic [31:0] v;
    for (int i = 0; i < 32; i++)
      v[i] = (kind == 0) ? mram[i][4][8] : (kind == 1) ? mram[i][4][15] : mram[i][3][15];
    return v;
  endfunction

  task automatic mwr(input int w, input int off, input logic [15:0] d);
    wr_reg(w, off, d);
    if (off == 1) mcm[w] = d[7:0];
    else if (off >= 2 && off <= 10) mwin[w][off-2] = d;
  endtask

  task automatic run(input int w, input int obj, input string tag);
    logic [15:0] r;
    int n = 0;
    wr_reg(w, 0, 16'(obj));
    for (int i = 0; i < 20; i++) begin
      rd_reg(w, 0, r);
      if (!r[15]) break;
      n++;
      @(negedge clk);
    end
    model_xfer(w, obj);
    chk(n == ((obj >= 1 && obj <= 32) ? 4 : 1), {tag, " busy length"}, n, (obj >= 1 && obj <= 32) ? 4 : 1);
    chk(r == 16'(obj & 63), {tag, " request readback"}, r, obj & 63);
  endtask

  task automatic cmp_win(input int w, input string tag);
    logic [15:0] r;
    bit ok = 1;
    logic [15:0] bad_a = 0, bad_e = 0;
    for (int k = 0; k < 9; k++) begin
      rd_reg(w, k + 2, r);
      if (r !== mwin[w][k]) begin ok = 0; bad_a = r; bad_e = mwin[w][k]; end
    end
    rd_reg(w, 1, r);
    if (r !== {8'h00, mcm[w]}) begin ok = 0; bad_a = r; bad_e = {8'h00, mcm[w]}; end
    chk(ok, {tag, " window contents"}, bad_a, bad_e);
  endtask

  task automatic cmp_vec(input string tag);
    chk(txreq_vec === vec(0), {tag, " txreq_vec"}, txreq_vec, vec(0));
    chk(newdat_vec === vec(1), {tag, " newdat_vec"}, newdat_vec, vec(1));
    chk(msgval_vec === vec(2), {tag, " msgval_vec"}, msgval_vec, vec(2));
  endtask

  function automatic logic [15:0] pack(input logic [7:0] lo, input logic [7:0] hi);
    return {hi, lo};
  endfunction

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [15:0] r;
    logic [7:0]  bytes [8];
    bit ok;
    void'($urandom(32'h5eed));
    for (int o = 0; o < 32; o++) for (int k = 0; k < 9; k++) mram[o][k] = 0;
    for (int w = 0; w < 2; w++) begin mcm[w] = 0; for (int k = 0; k < 9; k++) mwin[w][k] = 0; end

    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    ok = 1;
    for (int w = 0; w < 2; w++) for (int off = 0; off < 16; off++) begin
      rd_reg(w, off, r);
      if (r !== 0) ok = 0;
    end
    chk(ok, "R1 registers zero", r, 0);
    cmp_vec("R1");

    // R6 standard id 0x5A3 into arb2 bits 12:2, valid + transmit direction
    mwr(0, 5, 16'h8000 | 16'h2000 | (16'h05A3 << 2));
    mwr(0, 4, 16'h0000);
    mwr(0, 1, 8'h42);
    run(0, 5, "R6 std id");
    cmp_vec("R6 std id");

    // R6 extended id 0x1ABCDEF0: bits 28:16 in arb2 12:0, 15:0 in arb1
    mwr(1, 5, 16'hC000 | 16'(32'h1ABCDEF0 >> 16) & 16'h1FFF);
    mwr(1, 4, 16'hDEF0);
    mwr(1, 1, 8'h42);
    run(1, 20, "R6 ext id");
    cmp_vec("R6 ext id");

    // R6 little-endian data via window 1, load back through window 2
    for (int b = 0; b < 8; b++) bytes[b] = 8'(8'h11 * (b + 1));
    mwr(0, 7, pack(bytes[0], bytes[1]));
    mwr(0, 8, pack(bytes[2], bytes[3]));
    mwr(0, 9, pack(bytes[4], bytes[5]));
    mwr(0, 10, pack(bytes[6], bytes[7]));
    mwr(0, 1, 8'h58);
    run(0, 9, "R3 data store");
    mwr(1, 1, 8'h18);
    run(1, 9, "R3 data load");
    rd_reg(1, 7, r);
    chk(r[7:0] == bytes[0] && r[15:8] == bytes[1], "R6 byte order", r, {bytes[1], bytes[0]});
    cmp_win(1, "R3 data load");

    // R3 load with only data B: data A in window unchanged
    mwr(1, 7, 16'hAAAA);
    mwr(1, 9, 16'hBBBB);
    mwr(1, 1, 8'h10);
    run(1, 9, "R3 partial load");
    cmp_win(1, "R3 partial load");

    // R4 transmit request with control not selected
    mwr(0, 1, 8'h60);
    run(0, 3, "R4 txset");
    chk(txreq_vec[2] === 1'b1, "R4 txreq set", txreq_vec, vec(0));
    // R4 txset bit on a load has no effect
    mwr(0, 1, 8'h20);
    run(0, 4, "R4 load");
    cmp_vec("R4 load");

    // R5 new data ack
    mwr(1, 6, 16'h8003);
    mwr(1, 1, 8'h41);
    run(1, 7, "R5 store");
    chk(newdat_vec[6] === 1'b1, "R5 newdat set", newdat_vec, vec(1));
    mwr(1, 6, 16'h0000);
    mwr(1, 1, 8'h81);
    run(1, 7, "R5 ack load");
    rd_reg(1, 6, r);
    chk(r == 16'h8003, "R5 window keeps new data", r, 16'h8003);
    chk(newdat_vec[6] === 1'b0, "R5 newdat cleared", newdat_vec, vec(1));
    // R5 ack bit on store does nothing extra
    mwr(1, 6, 16'h8000);
    mwr(1, 1, 8'hC1);
    run(1, 8, "R5 ack store");
    cmp_vec("R5 ack store");

    // R7 writes during busy ignored; other window still writable
    mwr(0, 1, 8'h08);
    wr_reg(0, 0, 16'd9);
    wr_reg(0, 7, 16'hDEAD);
    wr_reg(0, 1, 16'h00FF);
    wr_reg(1, 7, 16'h1234);
    mwin[1][5] = 16'h1234;
    repeat (3) @(negedge clk);
    model_xfer(0, 9);
    rd_reg(0, 0, r);
    chk(r == 16'd9, "R7 request kept", r, 9);
    cmp_win(0, "R7 busy writes ignored");
    cmp_win(1, "R7 other window written");

    // R8 bad object numbers
    mwr(0, 5, 16'h0000);
    mwr(0, 1, 8'h5F);
    run(0, 0, "R8 object 0");
    run(0, 40, "R8 object 40");
    run(0, 33, "R8 object 33");
    cmp_vec("R8");

    // R9 unused offsets
    wr_reg(0, 12, 16'hFFFF);
    rd_reg(0, 12, r);
    chk(r == 0, "R9 unused offset", r, 0);
    cmp_win(0, "R9");

    // R3 random mixes
    for (int it = 0; it < 250; it++) begin
      int w, obj, nw;
      w = $urandom % 2;
      nw = $urandom % 4;
      for (int j = 0; j < nw; j++) mwr(w, 2 + ($urandom % 9), 16'($urandom));
      mwr(w, 1, 16'($urandom % 256));
      obj = ($urandom % 8 == 0) ? ($urandom % 64) : 1 + ($urandom % 32);
      run(w, obj, "R3 random");
      cmp_win(w, "R3 random");
      cmp_vec("R3 random");
    end

    // R2 full dump of every object through window 2
    ok = 1;
    mwr(1, 1, 8'h1F);
    for (int o = 1; o <= 32; o++) begin
      wr_reg(1, 0, 16'(o));
      repeat (4) @(negedge clk);
      model_xfer(1, o);
      for (int k = 0; k < 9; k++) begin
        rd_reg(1, k + 2, r);
        if (r !== mwin[1][k]) ok = 0;
      end
    end
    chk(ok, "R2 object dump", r, 0);

    // R6 initial clearing: objects 1-16 via window 1, 17-32 via window 2
    mwr(0, 4, 0); mwr(0, 5, 0); mwr(0, 1, 8'h42);
    mwr(1, 4, 0); mwr(1, 5, 0); mwr(1, 1, 8'h42);
    for (int o = 1; o <= 16; o++) begin
      run(0, o, "R6 clear w1");
      run(1, o + 16, "R6 clear w2");
    end
    chk(msgval_vec === 32'h0, "R6 all invalid", msgval_vec, 0);
    cmp_vec("R6 clear");

    summary();
  end
endmodule